// File: doc/BRIEF.md
# Three-Bit Gray Counter on JK State Memory

This block counts through the eight three-bit codes of a reflected Gray sequence, so that only one output bit moves on each step. Its state memory is three JK flip-flop cells rather than one vector register. A separate input-forming stage computes every J and K pin from excitation equations that were reduced by hand. The top level only wires these pieces together and adds a registered pulse that marks the end of each lap.

The named states, in counting order, are ST_G0 `000`, ST_G1 `001`, ST_G2 `011`, ST_G3 `010`, ST_G4 `110`, ST_G5 `111`, ST_G6 `101` and ST_G7 `100`. Each counting edge takes the transition from one state to the next in that list. The transition from ST_G7 back to ST_G0 is the wrap transition. When enable is low, every state loops on itself. A synchronous reset takes any state to ST_G0.

Top module: `gray_jk_counter`

## Requirements
- R1: With `en_i` high and `rst_i` low, every rising edge moves `count_o` to the next code of the order 000, 001, 011, 010, 110, 111, 101, 100, and then back to 000.
- R2: On every counting edge, exactly one bit of `count_o` changes.
- R3: The JK cell acts on a rising edge: with J=0 and K=0 it keeps its value, with J=0 and K=1 it clears, with J=1 and K=0 it sets, and with J=1 and K=1 it inverts. A high cell reset clears it whatever J and K are.
- R4: While `en_i` is low and `rst_i` is low, `count_o` keeps its value and `wrap_o` stays low.
- R5: With `rst_i` high at a rising edge, `count_o` becomes 000 and `wrap_o` becomes 0 after that edge. This holds whatever `en_i` is and whatever the current state is.
- R6: `wrap_o` is 1 for exactly the one cycle that follows an edge at which `count_o` was 100, `en_i` was high and `rst_i` was low. After every other edge it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable; the state holds while it is low |
| count_o | output | 3 | Current Gray code held in the JK cells |
| wrap_o | output | 1 | One-cycle pulse after the 100 to 000 step |

## Verification
The toggle case of the JK cell (J=1 and K=1) can never be reached from the counter's ports. Each J/K pair produced by the excitation equations is mutually exclusive, so the counter never drives both pins high at once. For that reason, the bench also drives a standalone JK cell directly and sweeps every combination of J, K and the prior state. The bench also has to bring the counter to state 100 before it can check that a reset at that point suppresses the wrap pulse. It does this by counting seven steps from reset and then asserting reset together with enable.

// File: rtl/gray_jk_pkg.sv
package gray_jk_pkg;
    localparam int unsigned STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_G0 = 3'b000,
        ST_G1 = 3'b001,
        ST_G2 = 3'b011,
        ST_G3 = 3'b010,
        ST_G4 = 3'b110,
        ST_G5 = 3'b111,
        ST_G6 = 3'b101,
        ST_G7 = 3'b100
    } g_state_e;
endpackage

// File: rtl/jk_cell.sv
module jk_cell (
    input  logic clk_i,
    input  logic rst_i,
    input  logic j_i,
    input  logic k_i,
    output logic q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= 1'b0;
        end else begin
            unique case ({j_i, k_i})
                2'b00: q_o <= q_o;
                2'b01: q_o <= 1'b0;
                2'b10: q_o <= 1'b1;
                2'b11: q_o <= ~q_o;
                default: q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/gray_excite.sv
module gray_excite
    import gray_jk_pkg::*;
(
    input  logic [STATE_W-1:0] q_i,
    input  logic               en_i,
    output logic [STATE_W-1:0] j_o,
    output logic [STATE_W-1:0] k_o
);
    logic [STATE_W-1:0] j_raw;
    logic [STATE_W-1:0] k_raw;

    always_comb begin
        // bit 2
        j_raw[2] =  q_i[1] & ~q_i[0];
        k_raw[2] = ~q_i[1] & ~q_i[0];
        // bit 1
        j_raw[1] = ~q_i[2] &  q_i[0];
        k_raw[1] =  q_i[2] &  q_i[0];
        // bit 0
        k_raw[0] =  q_i[2] ^ q_i[1];
        j_raw[0] = ~k_raw[0];
        // gating: all pins low means every cell holds
        j_o = en_i ? j_raw : '0;
        k_o = en_i ? k_raw : '0;
    end
endmodule

// File: rtl/gray_jk_counter.sv
module gray_jk_counter
    import gray_jk_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    output logic [STATE_W-1:0] count_o,
    output logic               wrap_o
);
    logic [STATE_W-1:0] q;
    logic [STATE_W-1:0] j_pins;
    logic [STATE_W-1:0] k_pins;
    g_state_e           cur_st;
    logic               at_last;
    logic               wrap_q;

    gray_excite excite_i (
        .q_i  (q),
        .en_i (en_i),
        .j_o  (j_pins),
        .k_o  (k_pins)
    );

    for (genvar b = 0; b < STATE_W; b++) begin : g_cells
        jk_cell cell_i (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .j_i   (j_pins[b]),
            .k_i   (k_pins[b]),
            .q_o   (q[b])
        );
    end

    always_comb begin
        cur_st  = g_state_e'(q);
        at_last = 1'b0;
        unique case (cur_st)
            ST_G7:   at_last = 1'b1;
            default: at_last = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= en_i & at_last;
        end
    end

    assign count_o = q;
    assign wrap_o  = wrap_q;
endmodule

// File: rtl/gray_jk_checker.sv
module gray_jk_checker
    import gray_jk_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               en_i,
    input logic [STATE_W-1:0] count_o,
    input logic               wrap_o
);
    function automatic logic [STATE_W-1:0] succ(input logic [STATE_W-1:0] g);
        logic [STATE_W-1:0] bin;
        bin[STATE_W-1] = g[STATE_W-1];
        for (int i = STATE_W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ g[i];
        bin = bin + 1'b1;
        return bin ^ (bin >> 1);
    endfunction

    a_r1_next_code: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> count_o == succ($past(count_o)));

    a_r2_one_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> $countones(count_o ^ $past(count_o)) == 1);

    a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(count_o) && !wrap_o);

    a_r5_reset: assert property (@(posedge clk_i)
        rst_i |=> count_o == '0 && !wrap_o);

    a_r6_wrap_set: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && count_o == 3'b100) |=> wrap_o && count_o == '0);

    a_r6_wrap_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        !(en_i && count_o == 3'b100) |=> !wrap_o);
endmodule

bind gray_jk_counter gray_jk_checker chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .count_o (count_o),
    .wrap_o  (wrap_o)
);

// File: tb/gray_jk_counter_tb_top.sv
module gray_jk_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [2:0] count;
    logic       wrap;
    logic       c_rst, c_j, c_k, c_q;
    int         checks = 0;
    int         errors = 0;
    int         idx    = 0;
    logic       exp_wrap = 1'b0;
    logic [2:0] prev;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    gray_jk_counter dut_i (
        .clk_i (clk), .rst_i (rst), .en_i (en),
        .count_o (count), .wrap_o (wrap)
    );

    jk_cell cell_i (.clk_i (clk), .rst_i (c_rst), .j_i (c_j), .k_i (c_k), .q_o (c_q));

    function automatic logic [2:0] gray_of(input int n);
        logic [2:0] b;
        b = 3'(n);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r; en = e;
        prev = count;
        @(posedge clk);
        #1;
        if (r) begin idx = 0; exp_wrap = 1'b0; end
        else if (e) begin exp_wrap = (idx == 7); idx = (idx + 1) % 8; end
        else exp_wrap = 1'b0;
        if (r) begin
            chk("R5 count", count, 3'b000);
            chk("R5 wrap", {2'b0, wrap}, {2'b0, exp_wrap});
        end else if (e) begin
            chk("R1 sequence", count, gray_of(idx));
            chk("R2 one bit", 3'($countones(count ^ prev)), 3'd1);
            chk("R6 wrap", {2'b0, wrap}, {2'b0, exp_wrap});
        end else begin
            chk("R4 hold", count, prev);
            chk("R4 wrap low", {2'b0, wrap}, 3'b0);
        end
    endtask

    task automatic cell_step(input logic r, input logic j, input logic k);
        @(negedge clk);
        c_rst = r; c_j = j; c_k = k;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0;
        c_rst = 1'b1; c_j = 1'b0; c_k = 1'b0;
        step(1'b1, 1'b0);
        chk("R5 reset state", count, 3'b000);
        // R1 R2 R6: three full laps
        for (int i = 0; i < 24; i++) step(1'b0, 1'b1);
        // R4: hold in every state, alternating enable
        for (int i = 0; i < 16; i++) step(1'b0, i[0]);
        for (int i = 0; i < 8; i++) step(1'b0, (i % 3) != 0);
        // R5: reset in mid-count with enable high
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        // R5 R6: reach 100, then reset with enable high, so no wrap
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
        chk("R6 at last code", count, 3'b100);
        step(1'b1, 1'b1);
        // hold at 100 with enable low: no wrap (R4)
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // R3: exhaustive sweep of the standalone JK cell
        for (int q0 = 0; q0 < 2; q0++) begin
            for (int jk = 0; jk < 4; jk++) begin
                logic ex;
                cell_step(1'b1, 1'b0, 1'b0);
                if (q0 == 1) cell_step(1'b0, 1'b1, 1'b0);
                chk("R3 preset", {2'b0, c_q}, 3'(q0));
                cell_step(1'b0, jk[1], jk[0]);
                case (jk)
                    0: ex = q0[0];
                    1: ex = 1'b0;
                    2: ex = 1'b1;
                    default: ex = ~q0[0];
                endcase
                chk("R3 jk", {2'b0, c_q}, {2'b0, ex});
            end
        end
        cell_step(1'b0, 1'b1, 1'b0);
        cell_step(1'b1, 1'b1, 1'b0);
        chk("R3 cell reset", {2'b0, c_q}, 3'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule